// File: doc/BRIEF.md
# Two-Level Page Table Walker with Leaf Permission Check

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A caller raises a request strobe together with the virtual address, the kind of access (instruction fetch, data load or data store), the current privilege level (user or supervisor) and two status controls. The first control lets supervisor code load and store on user pages. The second lets loads read pages that are marked execute-only. The caller also supplies the physical page number of the root table and a translation-enable flag. The walker fetches table entries one at a time through a plain request/response memory port. Entries that point to a lower table send the walk down one level. The first leaf it finds is checked for validity, privilege and access rights.

The walk ends with a one-cycle completion pulse. With the pulse come either a fault flag or a physical address. The block then goes idle and can take the next request. A supervisor instruction fetch from a user page is always refused. The user-page control opens such pages to supervisor loads and stores only. When translation is disabled the address passes straight through with no memory traffic.

Top module: `xlat_walker`

## Requirements
- R1: With xlatEn low at acceptance, done rises in the cycle right after the accepting edge with fault low and paddr equal to reqVaddr zero-extended to 34 bits, and no memory read is issued.
- R2: The first read goes to rootPpn*4096 + reqVaddr[31:22]*4. An entry with V=1 and R=W=X=0 is a pointer: the next read goes to entry[31:10]*4096 + reqVaddr[21:12]*4. Entry bits are V=0, R=1, W=2, X=3, U=4 and PPN=[31:10]. Every read address is word aligned.
- R3: A leaf that passes its checks at the second level gives paddr = {entry[31:10], reqVaddr[11:0]}. A leaf that passes at the first level gives paddr = {entry[31:20], reqVaddr[21:0]}.
- R4: An entry with V=0, or with W=1 and R=0, ends the walk with a fault.
- R5: A pointer entry found at the second level ends the walk with a fault.
- R6: On a leaf with U=1 in supervisor mode (reqSuper=1), a fetch faults whatever reqUserOk is. A load or store faults unless reqUserOk=1.
- R7: On a leaf with U=0, any access in user mode (reqSuper=0) faults. Supervisor access is not refused on privilege grounds.
- R8: Access codes are reqAccess 0 = fetch, 1 = load and 2 = store. A fetch needs X=1 and a store needs W=1. A load needs R=1, or X=1 when reqExecRd=1. Otherwise the leaf faults.
- R9: After reset, done and memReqValid are low and fault and paddr read zero. done is a single-cycle pulse. It rises in the cycle after the edge that samples the last memory response. When fault is high, paddr reads zero.
- R10: memReqValid is a one-cycle strobe. It rises in the cycle after acceptance, or after a pointer response, and no further strobe comes until a response is taken. A reqValid seen from acceptance until done has pulsed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqVaddr | input | 32 | Virtual address |
| reqAccess | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| reqSuper | input | 1 | 1 = supervisor, 0 = user |
| reqUserOk | input | 1 | Allow supervisor loads/stores on user pages |
| reqExecRd | input | 1 | Allow loads from execute-only pages |
| xlatEn | input | 1 | Translation enable |
| rootPpn | input | 22 | Physical page number of the root table |
| memReqValid | output | 1 | Table entry read strobe |
| memReqAddr | output | 34 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Table entry read data |
| done | output | 1 | Walk complete pulse |
| fault | output | 1 | Page fault, valid with done |
| paddr | output | 34 | Physical address, valid with done |

## Verification
In bypass mode the result is due in the cycle right after the accepting edge. A translated walk costs one cycle to issue each entry read plus that read's response latency. The result therefore appears a number of cycles after acceptance equal to the sum, over all reads, of one plus the latency. The bench's memory model draws a latency of one to three cycles for every read and keeps the running total. The bench samples 1 ns after each edge, counts edges from acceptance until done and compares that count with the model's total, and checks that done falls on the next edge.

// File: rtl/xw_pkg.sv
package xw_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } walk_st_e;

  // Strobes from control to datapath, at most one of the result strobes per cycle
  typedef struct packed {
    logic capture;    // latch the request, load root base and top level
    logic bare;       // with capture: pass the address through untranslated
    logic descend;    // pointer entry: load next base, drop one level
    logic leafOk;     // leaf accepted: record translated address
    logic leafFault;  // walk refused: record fault
  } walk_ctl_t;

  // Entry flag positions
  localparam int FlagV = 0;
  localparam int FlagR = 1;
  localparam int FlagW = 2;
  localparam int FlagX = 3;
  localparam int FlagU = 4;

endpackage

// File: rtl/xw_perm_check.sv
module xw_perm_check
  import xw_pkg::*;
(
  input  logic flagV,
  input  logic flagR,
  input  logic flagW,
  input  logic flagX,
  input  logic flagU,
  input  acc_e access,
  input  logic isSuper,
  input  logic userOk,
  input  logic execRd,
  output logic isPtr,
  output logic leafOk
);

  logic malformed;
  logic privFault;
  logic rightOk;

  // Invalid entries and the write-without-read code are refused outright
  assign malformed = !flagV || (flagW && !flagR);

  // With W excluded above, no R and no X marks a pointer to the next table
  assign isPtr = !malformed && !flagR && !flagX;

  always_comb begin
    if (flagU) begin
      privFault = isSuper && ((access == ACC_FETCH) || !userOk);
    end else begin
      privFault = !isSuper;
    end
  end

  always_comb begin
    unique case (access)
      ACC_FETCH: rightOk = flagX;
      ACC_LOAD:  rightOk = flagR || (execRd && flagX);
      default:   rightOk = flagW;
    endcase
  end

  assign leafOk = !malformed && !isPtr && !privFault && rightOk;

endmodule

// File: rtl/xw_datapath.sv
module xw_datapath
  import xw_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int VPN_W  = 10,
  parameter int LEVELS = 2,
  parameter int PPN_W  = 22,
  parameter int PTE_W  = 32,
  localparam int VA_W  = OFF_W + LEVELS * VPN_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  walk_ctl_t        ctl,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic             reqSuper,
  input  logic             reqUserOk,
  input  logic             reqExecRd,
  input  logic [PPN_W-1:0] rootPpn,
  input  logic [PTE_W-1:0] memRspData,
  output logic [PA_W-1:0]  memReqAddr,
  output logic             pteIsPtr,
  output logic             pteLeafOk,
  output logic             atLastLevel,
  output logic [PA_W-1:0]  paddr,
  output logic             fault
);

  localparam int EntryShift = $clog2(PTE_W / 8);
  localparam int FlagBits   = PTE_W - PPN_W;

  logic [VA_W-1:0]  vaQ;
  acc_e             accQ;
  logic             superQ;
  logic             userOkQ;
  logic             execRdQ;
  logic [PPN_W-1:0] basePpnQ;
  logic [LVL_W-1:0] levelQ;
  logic [PA_W-1:0]  paddrQ;
  logic             faultQ;

  logic [PPN_W-1:0] ptePpn;
  logic [VPN_W-1:0] vpnArr [LEVELS];
  logic [PA_W-1:0]  paArr  [LEVELS];
  logic [PA_W-1:0]  vaExt;
  logic [VPN_W-1:0] vpnSel;
  logic             unusedFlags;

  assign ptePpn      = memRspData[PTE_W-1 -: PPN_W];
  assign unusedFlags = ^memRspData[FlagBits-1:FlagU+1];
  assign vaExt       = PA_W'(vaQ);

  // Per-level index fields and leaf address merges
  for (genvar g = 0; g < LEVELS; g++) begin : gLevel
    localparam int LowBits = OFF_W + g * VPN_W;
    localparam logic [PA_W-1:0] LowMask = {{(PA_W - LowBits){1'b0}}, {LowBits{1'b1}}};
    assign vpnArr[g] = vaQ[OFF_W + g * VPN_W +: VPN_W];
    assign paArr[g]  = ({ptePpn, {OFF_W{1'b0}}} & ~LowMask) | (vaExt & LowMask);
  end

  assign vpnSel      = vpnArr[levelQ];
  assign memReqAddr  = {basePpnQ, {OFF_W{1'b0}}} + PA_W'({vpnSel, {EntryShift{1'b0}}});
  assign atLastLevel = (levelQ == '0);

  xw_perm_check u_perm (
    .flagV   (memRspData[FlagV]),
    .flagR   (memRspData[FlagR]),
    .flagW   (memRspData[FlagW]),
    .flagX   (memRspData[FlagX]),
    .flagU   (memRspData[FlagU]),
    .access  (accQ),
    .isSuper (superQ),
    .userOk  (userOkQ),
    .execRd  (execRdQ),
    .isPtr   (pteIsPtr),
    .leafOk  (pteLeafOk)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ      <= '0;
      accQ     <= ACC_FETCH;
      superQ   <= 1'b0;
      userOkQ  <= 1'b0;
      execRdQ  <= 1'b0;
      basePpnQ <= '0;
      levelQ   <= '0;
      paddrQ   <= '0;
      faultQ   <= 1'b0;
    end else begin
      if (ctl.capture) begin
        vaQ      <= reqVaddr;
        accQ     <= acc_e'(reqAccess);
        superQ   <= reqSuper;
        userOkQ  <= reqUserOk;
        execRdQ  <= reqExecRd;
        basePpnQ <= rootPpn;
        levelQ   <= LVL_W'(LEVELS - 1);
        faultQ   <= 1'b0;
        paddrQ   <= ctl.bare ? PA_W'(reqVaddr) : '0;
      end
      if (ctl.descend) begin
        basePpnQ <= ptePpn;
        levelQ   <= levelQ - 1'b1;
      end
      if (ctl.leafOk) begin
        paddrQ <= paArr[levelQ];
        faultQ <= 1'b0;
      end
      if (ctl.leafFault) begin
        paddrQ <= '0;
        faultQ <= 1'b1;
      end
    end
  end

  assign paddr = paddrQ;
  assign fault = faultQ;

endmodule

// File: rtl/xw_control.sv
module xw_control
  import xw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      xlatEn,
  input  logic      memRspValid,
  input  logic      pteIsPtr,
  input  logic      pteLeafOk,
  input  logic      atLastLevel,
  output walk_ctl_t ctl,
  output logic      memReqValid,
  output logic      done
);

  walk_st_e stateQ;
  walk_st_e stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capture = 1'b1;
          if (!xlatEn) begin
            ctl.bare  = 1'b1;
            stateNext = ST_FINISH;
          end else begin
            stateNext = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (pteIsPtr && !atLastLevel) begin
            ctl.descend = 1'b1;
            stateNext   = ST_ISSUE;
          end else if (pteLeafOk) begin
            ctl.leafOk = 1'b1;
            stateNext  = ST_FINISH;
          end else begin
            ctl.leafFault = 1'b1;
            stateNext     = ST_FINISH;
          end
        end
      end
      default: begin
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateNext;
    end
  end

  assign memReqValid = (stateQ == ST_ISSUE);
  assign done        = (stateQ == ST_FINISH);

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int VPN_W  = 10,
  parameter int LEVELS = 2,
  parameter int PPN_W  = 22,
  parameter int PTE_W  = 32,
  localparam int VA_W  = OFF_W + LEVELS * VPN_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic             reqSuper,
  input  logic             reqUserOk,
  input  logic             reqExecRd,
  input  logic             xlatEn,
  input  logic [PPN_W-1:0] rootPpn,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [PTE_W-1:0] memRspData,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  paddr
);

  walk_ctl_t ctl;
  logic      pteIsPtr;
  logic      pteLeafOk;
  logic      atLastLevel;

  xw_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .xlatEn      (xlatEn),
    .memRspValid (memRspValid),
    .pteIsPtr    (pteIsPtr),
    .pteLeafOk   (pteLeafOk),
    .atLastLevel (atLastLevel),
    .ctl         (ctl),
    .memReqValid (memReqValid),
    .done        (done)
  );

  xw_datapath #(
    .OFF_W  (OFF_W),
    .VPN_W  (VPN_W),
    .LEVELS (LEVELS),
    .PPN_W  (PPN_W),
    .PTE_W  (PTE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqVaddr    (reqVaddr),
    .reqAccess   (reqAccess),
    .reqSuper    (reqSuper),
    .reqUserOk   (reqUserOk),
    .reqExecRd   (reqExecRd),
    .rootPpn     (rootPpn),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .pteIsPtr    (pteIsPtr),
    .pteLeafOk   (pteLeafOk),
    .atLastLevel (atLastLevel),
    .paddr       (paddr),
    .fault       (fault)
  );

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
  parameter int PA_W = 34
) (
  input logic            clk,
  input logic            rstN,
  input logic            memReqValid,
  input logic [PA_W-1:0] memReqAddr,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] paddr
);

  p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[1:0] == 2'b00));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_fault_no_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (paddr == '0));

  p_read_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  p_no_read_at_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReqValid);

endmodule

bind xlat_walker xlat_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .done        (done),
  .fault       (fault),
  .paddr       (paddr)
);

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;

  localparam logic [4:0] FV = 5'h01;
  localparam logic [4:0] FR = 5'h02;
  localparam logic [4:0] FW = 5'h04;
  localparam logic [4:0] FX = 5'h08;
  localparam logic [4:0] FU = 5'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqSuper = 1'b0;
  logic        reqUserOk = 1'b0;
  logic        reqExecRd = 1'b0;
  logic        xlatEn = 1'b0;
  logic [21:0] rootPpn = '0;
  logic        memReqValid;
  logic [33:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        done;
  logic        fault;
  logic [33:0] paddr;

  always #4 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .reqSuper(reqSuper), .reqUserOk(reqUserOk),
    .reqExecRd(reqExecRd), .xlatEn(xlatEn), .rootPpn(rootPpn),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .done(done), .fault(fault), .paddr(paddr)
  );

  logic [31:0] ptMem [0:2047];
  logic [33:0] readAddr [0:3];
  int checks = 0;
  int errors = 0;
  int readCnt = 0;
  int latSum = 0;
  bit finished = 1'b0;

  task automatic checkVal(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkPte(input logic [21:0] ppn, input logic [4:0] fl);
    return {ppn, 5'b0, fl};
  endfunction

  function automatic logic [31:0] mkVa(input logic [9:0] v1, input logic [9:0] v0, input logic [11:0] off);
    return {v1, v0, off};
  endfunction

  // Reference walk from the requirements, reading the bench's own table image
  function automatic void refWalk(input logic [31:0] va, input logic [1:0] acc,
                                  input logic sup, input logic uok, input logic xrd,
                                  input logic en, input logic [21:0] root,
                                  output logic f, output logic [33:0] pa, output int nRd,
                                  output logic [33:0] a0, output logic [33:0] a1);
    logic [21:0] base;
    logic [33:0] addr;
    logic [31:0] pte;
    logic v, r, w, x, u, priv, right;
    nRd = 0; f = 1'b0; pa = '0; a0 = '0; a1 = '0;
    if (!en) begin
      pa = {2'b00, va};
      return;
    end
    base = root;
    for (int lvl = 1; lvl >= 0; lvl--) begin
      addr = {base, 12'h000} + {22'h0, (lvl == 1) ? va[31:22] : va[21:12], 2'b00};
      if (nRd == 0) a0 = addr; else a1 = addr;
      nRd++;
      pte = ptMem[addr[12:2]];
      v = pte[0]; r = pte[1]; w = pte[2]; x = pte[3]; u = pte[4];
      if (!v || (w && !r)) begin f = 1'b1; return; end
      if (!r && !x) begin
        if (lvl == 0) begin f = 1'b1; return; end
        base = pte[31:10];
        continue;
      end
      priv  = u ? (sup && (acc == 2'd0 || !uok)) : !sup;
      right = (acc == 2'd0) ? x : (acc == 2'd1) ? (r || (xrd && x)) : w;
      if (priv || !right) begin f = 1'b1; return; end
      pa = (lvl == 1) ? {pte[31:20], va[21:0]} : {pte[31:10], va[11:0]};
      return;
    end
  endfunction

  task automatic runReq(input string tag, input logic [31:0] va, input logic [1:0] acc,
                        input logic sup, input logic uok, input logic xrd, input logic en,
                        input logic [21:0] root, input bit poke);
    logic ef;
    logic [33:0] epa, ea0, ea1;
    int enr;
    int cyc;
    refWalk(va, acc, sup, uok, xrd, en, root, ef, epa, enr, ea0, ea1);
    readCnt = 0;
    latSum = 0;
    reqVaddr = va; reqAccess = acc; reqSuper = sup; reqUserOk = uok;
    reqExecRd = xrd; xlatEn = en; rootPpn = root; reqValid = 1'b1;
    @(posedge clk); #1;
    if (poke) reqVaddr = ~va;
    else reqValid = 1'b0;
    cyc = 0;
    while (!done && cyc < 60) begin
      @(posedge clk); #1;
      cyc++;
      if (cyc == 1) reqValid = 1'b0;
    end
    checkVal({tag, " R9 done seen"}, done, 1'b1);
    if (done) begin
      checkVal({tag, " R9 result latency"}, cyc, readCnt + latSum);
      checkVal({tag, " fault"}, fault, ef);
      checkVal({tag, " paddr"}, paddr, epa);
      checkVal({tag, " R10 read count"}, readCnt, enr);
      if (enr > 0 && readCnt > 0) checkVal({tag, " R2 first read address"}, readAddr[0], ea0);
      if (enr > 1 && readCnt > 1) checkVal({tag, " R2 second read address"}, readAddr[1], ea1);
    end
    @(posedge clk); #1;
    checkVal({tag, " R9 done single cycle"}, done, 1'b0);
  endtask

  // Table memory: one to three cycles of latency per read
  initial begin : memModel
    wait (rstN);
    @(posedge clk); #1;
    forever begin
      if (memReqValid) begin
        logic [33:0] a;
        int lat;
        a = memReqAddr;
        lat = $urandom_range(3, 1);
        if (readCnt < 4) readAddr[readCnt] = a;
        readCnt++;
        latSum += lat;
        repeat (lat) @(posedge clk);
        #1;
        memRspValid = 1'b1;
        memRspData = ptMem[a[12:2]];
        @(posedge clk); #1;
        memRspValid = 1'b0;
        memRspData = '0;
      end else begin
        @(posedge clk); #1;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] va;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) ptMem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    checkVal("reset R9 done", done, 1'b0);
    checkVal("reset R9 memReqValid", memReqValid, 1'b0);
    checkVal("reset R9 fault", fault, 1'b0);
    checkVal("reset R9 paddr", paddr, '0);

    // R1 bypass
    runReq("R1 bypass high addr", 32'hFFFF_F123, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 22'h3, 1'b0);
    runReq("R1 bypass low addr", 32'h0000_0ABC, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 22'h0, 1'b0);

    va = mkVa(10'd5, 10'd9, 12'h345);
    // R2 R3 two-level user load
    ptMem[5] = mkPte(22'h1, FV);
    ptMem[1024 + 9] = mkPte(22'h2ABCD, FV | FR | FU);
    runReq("R2 R3 two-level load", va, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 22'h0, 1'b0);
    runReq("R10 request ignored while busy", va, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 22'h0, 1'b1);

    // R3 first-level leaf
    ptMem[5] = mkPte(22'h3F_F800, FV | FR | FW | FX);
    runReq("R3 first-level leaf store", va, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 22'h0, 1'b0);

    // R4 malformed entries
    ptMem[5] = mkPte(22'h1, FV);
    ptMem[1033] = mkPte(22'h1234, FR | FU);
    runReq("R4 entry not valid", va, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 22'h0, 1'b0);
    ptMem[1033] = mkPte(22'h1234, FV | FW | FU);
    runReq("R4 write without read", va, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 22'h0, 1'b0);

    // R5 pointer at last level
    ptMem[1033] = mkPte(22'h1, FV);
    runReq("R5 pointer at last level", va, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 22'h0, 1'b0);

    // R6 supervisor on user page
    ptMem[1033] = mkPte(22'h0_5555, FV | FR | FX | FU);
    runReq("R6 super fetch user page", va, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 22'h0, 1'b0);
    runReq("R6 super load user page allowed", va, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 22'h0, 1'b0);
    runReq("R6 super load user page refused", va, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 22'h0, 1'b0);

    // R7 user on supervisor page
    ptMem[1033] = mkPte(22'h0_7777, FV | FX);
    runReq("R7 user fetch super page", va, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 22'h0, 1'b0);
    runReq("R7 super fetch super page", va, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 22'h0, 1'b0);

    // R8 access rights
    ptMem[1033] = mkPte(22'h0_9999, FV | FX | FU);
    runReq("R8 load exec-only allowed", va, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 22'h0, 1'b0);
    runReq("R8 load exec-only refused", va, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 22'h0, 1'b0);
    ptMem[1033] = mkPte(22'h0_9999, FV | FR | FU);
    runReq("R8 store read-only", va, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 22'h0, 1'b0);

    // R2 root in the upper table
    ptMem[1024 + 5] = mkPte(22'h0, FV);
    ptMem[9] = mkPte(22'h1_2345, FV | FR | FW | FU);
    runReq("R2 root at page one", va, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 22'h1, 1'b0);

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [9:0]  v1, v0;
      logic [21:0] root, ptr;
      int kind;
      v1 = 10'($urandom); v0 = 10'($urandom);
      root = 22'($urandom_range(1, 0));
      ptr  = 22'($urandom_range(1, 0));
      ptMem[{ptr[0], v0}] = {22'($urandom), 5'($urandom),
                             ($urandom_range(3, 0) != 0) ? ({4'($urandom), 1'b1}) : 5'($urandom)};
      kind = $urandom_range(3, 0);
      if (kind < 2) ptMem[{root[0], v1}] = mkPte(ptr, FV);
      else if (kind == 2) ptMem[{root[0], v1}] = {22'($urandom), 5'($urandom), 4'($urandom), 1'b1};
      else ptMem[{root[0], v1}] = $urandom;
      runReq("R2 R3 R4 R5 R6 R7 R8 random walk", mkVa(v1, v0, 12'($urandom)),
             2'($urandom_range(2, 0)), 1'($urandom), 1'($urandom), 1'($urandom),
             ($urandom_range(7, 0) != 0), root, 1'b0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule